// File: doc/BRIEF.md
# Peripheral Bus Protocol Compliance Monitor

A passive, synthesizable watcher placed on one APB subordinate port. It never drives the bus; it samples the select, enable, ready, direction, address, write-data and error-response lines on every rising clock edge. It tells the rest of the chip when a transfer finished, and it records any breach of the phase sequencing rules. A transfer finishes on the one edge where select, enable and ready are all high. Everything the monitor reports is tied to that edge.

Four violation classes are kept as sticky flags: enable without select, an access phase that did not follow a setup phase, a held signal that moved during a wait state, and enable held high straight after a completion. A one-cycle pulse marks each completion. Two saturating counters tally completed transfers and completed transfers that carried an error response. Data contents, address decoding and read data are outside its scope.

Top module: `apb_compliance_monitor`

## Requirements
- R1: While `rst_n` is low at a rising edge, all outputs clear on that edge: `viol_flags` = 0, `done_pulse` = 0, both counters = 0.
- R2: An edge where `sel`, `enable` and `ready` are all high is a completion. `done_pulse` is high for the cycle after that edge, and `xfer_count` goes up by one on that edge.
- R3: A wait cycle (`sel` and `enable` high, `ready` low) causes no `done_pulse` and no count change.
- R4: `err_count` goes up by one only on a completion edge where `slverr` is high. `slverr` at any other edge has no effect.
- R5: `viol_flags[0]` sets when `enable` is high while `sel` is low.
- R6: `viol_flags[1]` sets when `sel` and `enable` are both high but neither was high on the previous edge, so no setup cycle came first.
- R7: `viol_flags[2]` sets when the previous edge was a wait cycle and `addr`, `write`, `wdata` or `sel` now differs from its value on that edge.
- R8: `viol_flags[3]` sets when `enable` is high on the edge right after a completion.
- R9: A completion followed at once by a setup cycle with new address, data and direction raises no flag.
- R10: Every flag bit stays set until the next reset, which clears it.
- R11: Each counter holds at all-ones and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising-edge sampled |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Subordinate select |
| enable | input | 1 | Access-phase enable |
| ready | input | 1 | Subordinate ready |
| write | input | 1 | Direction, 1 = write |
| addr | input | ADDR_W | Transfer address |
| wdata | input | DATA_W | Write data |
| slverr | input | 1 | Error response |
| viol_flags | output | 4 | Sticky violation flags, bits as in R5 to R8 |
| done_pulse | output | 1 | One-cycle completion marker |
| xfer_count | output | CNT_W | Completed transfers, saturating |
| err_count | output | CNT_W | Completions with error response, saturating |

## Verification
The bench puts an error response on wait cycles but not on the completion edge. A design that sampled `slverr` outside completion would count a phantom error. It runs waits of several cycles, where a monitor keyed on enable alone would pulse or count more than once per transfer. It also drives a legal back-to-back pair in which every held signal changes straight after completion; a monitor that judged stability by cycle count rather than by the completion edge would flag it. Each violation is provoked alone, and the bench checks that it lights only its own bit, that the bit stays set while the bus is idle, and that reset clears it. With a narrowed counter it also drives more transfers than the counter can hold, so a wrapping counter shows up.

// File: rtl/apb_mon_pkg.sv
// Package: shared constants for the bus compliance monitor.
// Assumes: the flag vector layout below is fixed; consumers decode bits by index.
package apb_mon_pkg;
    localparam int VIOL_N        = 4;
    localparam int VB_EN_NOSEL   = 0;  // enable seen without select
    localparam int VB_NO_SETUP   = 1;  // access phase without a setup cycle
    localparam int VB_UNSTABLE   = 2;  // held signal moved after a wait cycle
    localparam int VB_AFTER_DONE = 3;  // enable still high after completion
endpackage

// File: rtl/apb_mon_history.sv
// Module: registers the bus lines sampled at the previous rising edge.
// Assumes: synchronous active-low reset; reset value is an idle bus.
module apb_mon_history #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              enable,
    input  logic              ready,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              h_sel,
    output logic              h_enable,
    output logic              h_ready,
    output logic              h_write,
    output logic [ADDR_W-1:0] h_addr,
    output logic [DATA_W-1:0] h_wdata
);
    // Capture control lines each edge; idle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_sel    <= 1'b0;
            h_enable <= 1'b0;
            h_ready  <= 1'b0;
            h_write  <= 1'b0;
        end else begin
            h_sel    <= sel;
            h_enable <= enable;
            h_ready  <= ready;
            h_write  <= write;
        end
    end

    // Capture address and write data each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_addr  <= '0;
            h_wdata <= '0;
        end else begin
            h_addr  <= addr;
            h_wdata <= wdata;
        end
    end
endmodule

// File: rtl/apb_mon_rules.sv
// Module: evaluates the sequencing and stability rules and keeps sticky flags.
// Assumes: h_* are the same lines one edge earlier; h_done marks that the
// previous edge was a completion.
module apb_mon_rules
    import apb_mon_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              enable,
    input  logic              ready,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              h_sel,
    input  logic              h_enable,
    input  logic              h_ready,
    input  logic              h_write,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    input  logic              h_done,
    output logic [VIOL_N-1:0] flags
);
    logic [VIOL_N-1:0] hit;
    logic              was_wait;
    logic              moved;

    // Previous edge was a wait cycle inside an access phase.
    always_comb was_wait = h_sel && h_enable && !h_ready;

    // Any held line differs from its value at the wait edge.
    always_comb moved = (addr != h_addr) || (wdata != h_wdata) ||
                        (write != h_write) || (sel != h_sel);

    // Per-edge rule evaluation.
    always_comb begin
        hit = '0;
        hit[VB_EN_NOSEL]   = enable && !sel;
        hit[VB_NO_SETUP]   = sel && enable && !h_enable && !h_sel;
        hit[VB_UNSTABLE]   = was_wait && moved;
        hit[VB_AFTER_DONE] = h_done && enable;
    end

    // One sticky flag per rule.
    for (genvar gi = 0; gi < VIOL_N; gi++) begin : g_flag
        // Set on first hit, hold until reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[gi] <= 1'b0;
            else if (hit[gi])
                flags[gi] <= 1'b1;
        end

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            flags[gi] |=> flags[gi]); // R10
    end

    AST_SETUP_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[VB_NO_SETUP]) |-> $past(sel && enable)); // R6
endmodule

// File: rtl/apb_mon_counter.sv
// Module: saturating event counter.
// Assumes: inc is a single-cycle qualifier; value holds at all-ones.
module apb_mon_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Count qualified events, stop at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (inc && (cnt != TOP))
            cnt <= cnt + 1'b1;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == TOP) |=> (cnt == TOP)); // R11

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt)); // R3
endmodule

// File: rtl/apb_compliance_monitor.sv
// Module: top of the passive bus compliance monitor.
// Assumes: one subordinate port, all lines synchronous to clk, synchronous
// active-low reset. Never drives the bus.
module apb_compliance_monitor
    import apb_mon_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              enable,
    input  logic              ready,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              slverr,
    output logic [VIOL_N-1:0] viol_flags,
    output logic              done_pulse,
    output logic [CNT_W-1:0]  xfer_count,
    output logic [CNT_W-1:0]  err_count
);
    logic              h_sel, h_enable, h_ready, h_write;
    logic [ADDR_W-1:0] h_addr;
    logic [DATA_W-1:0] h_wdata;
    logic              finish;
    logic              finish_err;

    // The single completion term every report keys off.
    always_comb finish = sel && enable && ready;

    // Error response only counts on the completion edge.
    always_comb finish_err = finish && slverr;

    // Completion marker, visible for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_pulse <= 1'b0;
        else
            done_pulse <= finish;
    end

    apb_mon_history #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_hist (
        .clk(clk), .rst_n(rst_n),
        .sel(sel), .enable(enable), .ready(ready), .write(write),
        .addr(addr), .wdata(wdata),
        .h_sel(h_sel), .h_enable(h_enable), .h_ready(h_ready),
        .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata)
    );

    apb_mon_rules #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rules (
        .clk(clk), .rst_n(rst_n),
        .sel(sel), .enable(enable), .ready(ready), .write(write),
        .addr(addr), .wdata(wdata),
        .h_sel(h_sel), .h_enable(h_enable), .h_ready(h_ready),
        .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_done(done_pulse),
        .flags(viol_flags)
    );

    apb_mon_counter #(.W(CNT_W)) i_xfer_cnt (
        .clk(clk), .rst_n(rst_n), .inc(finish), .cnt(xfer_count)
    );

    apb_mon_counter #(.W(CNT_W)) i_err_cnt (
        .clk(clk), .rst_n(rst_n), .inc(finish_err), .cnt(err_count)
    );

    AST_COUNT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_count != $past(xfer_count)) |-> done_pulse); // R2

    AST_ERR_LE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        err_count <= xfer_count); // R4

    AST_DONE_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (h_enable && h_sel)); // R3
endmodule

// File: tb/test_apb_compliance_monitor.sv
module test_apb_compliance_monitor;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 0, enable = 0, ready = 0, write = 0, slverr = 0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [3:0]    viol_flags;
    logic          done_pulse;
    logic [CW-1:0] xfer_count, err_count;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        string    tag;
        logic [3:0] fl;
        logic       dn;
        int         xc;
        int         ec;
    } exp_t;
    exp_t sb[$];

    // bench model of expected state
    logic [3:0] m_fl = '0;
    int m_xc = 0, m_ec = 0;

    always #5 clk = ~clk;

    apb_compliance_monitor #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_apb_compliance_monitor (
        .clk(clk), .rst_n(rst_n), .sel(sel), .enable(enable), .ready(ready),
        .write(write), .addr(addr), .wdata(wdata), .slverr(slverr),
        .viol_flags(viol_flags), .done_pulse(done_pulse),
        .xfer_count(xfer_count), .err_count(err_count)
    );

    task automatic chk(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // monitor: pop expectations away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, "flags", int'(viol_flags), int'(e.fl));
            chk(e.tag, "done", int'(done_pulse), int'(e.dn));
            chk(e.tag, "xfer", int'(xfer_count), e.xc);
            chk(e.tag, "err", int'(err_count), e.ec);
        end
    end

    task automatic push(string tag, logic dn);
        exp_t e;
        e.tag = tag; e.fl = m_fl; e.dn = dn; e.xc = m_xc; e.ec = m_ec;
        sb.push_back(e);
    endtask

    // one bus cycle: drive, then let the design sample it
    task automatic cyc(logic s, logic en, logic rd, logic wr,
                       logic [AW-1:0] a, logic [DW-1:0] d, logic er);
        sel = s; enable = en; ready = rd; write = wr; addr = a; wdata = d; slverr = er;
        @(posedge clk); #1;
        if (s && en && rd) begin
            if (m_xc < 15) m_xc++;
            if (er && m_ec < 15) m_ec++;
        end
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, '0, '0, 0);
    endtask

    task automatic do_reset();
        rst_n = 0;
        idle(); idle();
        rst_n = 1;
        m_fl = '0; m_xc = 0; m_ec = 0;
    endtask

    initial begin
        #1;
        do_reset();
        push("R1 reset state", 1'b0);

        // R2: write with no wait
        cyc(1, 0, 0, 1, 16'h0010, 32'hA5A5_0001, 0);
        push("R2 setup no pulse", 1'b0);
        cyc(1, 1, 1, 1, 16'h0010, 32'hA5A5_0001, 0);
        push("R2 completion", 1'b1);
        idle();
        push("R2 pulse one cycle", 1'b0);

        // R3/R4: read with two waits, error only during waits
        cyc(1, 0, 0, 0, 16'h0020, 32'h0, 1);
        cyc(1, 1, 0, 0, 16'h0020, 32'h0, 1);
        push("R3 first wait", 1'b0);
        cyc(1, 1, 0, 0, 16'h0020, 32'h0, 1);
        push("R3 second wait", 1'b0);
        cyc(1, 1, 1, 0, 16'h0020, 32'h0, 0);
        push("R4 err outside completion ignored", 1'b1);
        idle();

        // R4: error on completion
        cyc(1, 0, 0, 0, 16'h0030, 32'h0, 0);
        cyc(1, 1, 1, 0, 16'h0030, 32'h0, 1);
        push("R4 err on completion", 1'b1);

        // R9: back-to-back with everything changing after completion
        cyc(1, 0, 0, 1, 16'h0044, 32'h1234_5678, 0);
        push("R9 setup right after completion", 1'b0);
        cyc(1, 1, 0, 1, 16'h0044, 32'h1234_5678, 0);
        cyc(1, 1, 1, 1, 16'h0044, 32'h1234_5678, 0);
        cyc(1, 0, 0, 0, 16'h0048, 32'hFFFF_0000, 0);
        cyc(1, 1, 1, 0, 16'h0048, 32'hFFFF_0000, 0);
        push("R9 back-to-back clean", 1'b1);
        idle();
        push("R9 idle clean", 1'b0);

        // R5: enable without select
        do_reset();
        cyc(0, 1, 0, 0, '0, '0, 0);
        m_fl[0] = 1;
        push("R5 enable without select", 1'b0);
        idle(); idle();
        push("R10 flag sticky", 1'b0);

        // R10: reset clears
        do_reset();
        push("R10 reset clears", 1'b0);

        // R6: access with no setup
        cyc(1, 1, 1, 0, 16'h0050, '0, 0);
        m_fl[1] = 1;
        push("R6 missing setup", 1'b1);
        idle();

        // R7: address moves during wait
        do_reset();
        cyc(1, 0, 0, 1, 16'h0060, 32'h1, 0);
        cyc(1, 1, 0, 1, 16'h0060, 32'h1, 0);
        push("R7 wait stable so far", 1'b0);
        cyc(1, 1, 1, 1, 16'h0064, 32'h1, 0);
        m_fl[2] = 1;
        push("R7 address moved", 1'b1);
        idle();

        // R7: write data moves during wait
        do_reset();
        cyc(1, 0, 0, 1, 16'h0070, 32'h2, 0);
        cyc(1, 1, 0, 1, 16'h0070, 32'h2, 0);
        cyc(1, 1, 0, 1, 16'h0070, 32'h3, 0);
        m_fl[2] = 1;
        push("R7 write data moved", 1'b0);
        idle();

        // R8: enable held after completion
        do_reset();
        cyc(1, 0, 0, 0, 16'h0080, '0, 0);
        cyc(1, 1, 1, 0, 16'h0080, '0, 0);
        push("R8 first completion", 1'b1);
        cyc(1, 1, 1, 0, 16'h0080, '0, 0);
        m_fl[3] = 1;
        push("R8 enable after completion", 1'b1);
        idle();

        // R11: saturation
        do_reset();
        for (int i = 0; i < 18; i++) begin
            cyc(1, 0, 0, 1, 16'(i), 32'(i), 0);
            cyc(1, 1, 1, 1, 16'(i), 32'(i), 1);
        end
        push("R11 counters saturate", 1'b1);
        idle();

        @(negedge clk); #1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // watchdog
    initial begin
        #200000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule